// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block caches 64 page translations for a 32-bit processor with 4 KB pages. Each slot holds two words. The high word carries a virtual page number and an address-space tag field that is kept but never compared. The low word carries a physical page number and four flags: no-cache, dirty, valid and global. Any slot can hold any page. Software manages the table through a command port with four operations. Two write an entry: one into a named slot, one into a slot the block picks itself. A third reads an entry back. The fourth probes for a virtual page.

A second port translates load and store addresses. It returns the physical address, or one of three faults: miss, invalid or modify. Matching looks only at the virtual page number. Upper-half pages (page number 0x80000 and above) are unmapped space. Such addresses pass through untranslated, and a slot holding such a page never matches. Software can therefore clear the table by filling every slot with its own distinct unmapped dummy page. The dirty flag acts as write permission, and the hardware never changes it.

Top module: `tlb_assoc`

## Requirements
- R1: After reset, slot i holds the high word (0x80000 + i) << 12 and the low word 0, and `rspValid` and `lkDone` are low.
- R2: An indexed write (`cmdOp` = 0) stores into slot `cmdIndex`. A read (`cmdOp` = 2) returns that slot's words on `rspHi`/`rspLo` with `rspValid` high one cycle after the command. High-word bits 31:6 are kept and bits 5:0 read as zero. Low-word bits 31:8 are kept and bits 7:0 read as zero.
- R3: A probe (`cmdOp` = 3) compares `cmdHi[31:12]` against every slot, whatever the valid flag and the bits 11:6. One cycle later `rspProbe` gives the lowest matching slot index in bits 5:0 with bit 31 clear, or 0x80000000 when no slot matches.
- R4: When more than one slot matches, the probe raises `rspMulti` and the lookup raises `lkMulti`. In both cases the lowest matching slot is used.
- R5: A random write (`cmdOp` = 1) stores into the slot given by an internal counter. The counter is 63 on the first clock edge after reset and decreases by one on every edge, wrapping from 0 to 63.
- R6: A lookup (`lkValid`) produces `lkDone` one cycle later. When it hits a slot with valid (low-word bit 9) set and no fault applies, `lkPaddr` = {slot page, address bits 11:0}, `lkFault` = 0, and `lkNoCache` shows low-word bit 11.
- R7: A mapped lookup that matches no slot gives `lkFault` = 1 (miss), with `lkFaultVpn` = address bits 31:12.
- R8: A lookup that matches a slot whose valid flag is clear gives `lkFault` = 2 (invalid), with `lkFaultVpn` = address bits 31:12.
- R9: A store (`lkStore` high) that hits a valid slot whose dirty flag (low-word bit 10) is clear gives `lkFault` = 3 (modify). The same access as a load gives no fault. The dirty flag is never altered by hardware.
- R10: A lookup whose address has bit 31 set gives `lkPaddr` equal to the address and `lkFault` = 0. A slot whose page number has bit 19 set never matches a probe or a lookup.
- R11: A write becomes visible to a lookup issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 indexed write, 1 random write, 2 read, 3 probe |
| cmdIndex | input | 6 | Slot for indexed write and read |
| cmdHi | input | 32 | High word for writes; page key for probe |
| cmdLo | input | 32 | Low word for writes |
| rspValid | output | 1 | Read or probe result present |
| rspHi | output | 32 | High word read back |
| rspLo | output | 32 | Low word read back |
| rspProbe | output | 32 | Probe result: index or 0x80000000 |
| rspMulti | output | 1 | Probe found more than one match |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Virtual address to translate |
| lkStore | input | 1 | Access is a store |
| lkDone | output | 1 | Lookup result present |
| lkPaddr | output | 32 | Translated address |
| lkFault | output | 2 | 0 none, 1 miss, 2 invalid, 3 modify |
| lkFaultVpn | output | 20 | Page number of the looked-up address |
| lkNoCache | output | 1 | No-cache flag of the hit slot |
| lkMulti | output | 1 | Lookup found more than one match |

## Verification
The hardest state to reach from the ports is two slots holding the same page. Software is told never to create it, and the random write would bury it in an unpredictable slot. The bench therefore uses two indexed writes of one page into slots 20 and 5. It then probes and looks up that page, expecting slot 5, the multiple-match flags, and the invalid fault that comes from slot 5's clear valid flag. The random-slot checks work out the expected slot by counting clock edges since reset.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int ENTRY_CNT = 64;
  parameter int IDX_W = $clog2(ENTRY_CNT);
  parameter int WORD_W = 32;
  parameter int PAGE_BITS = 12;
  parameter int VPN_W = WORD_W - PAGE_BITS;

  // low-word flag positions
  parameter int NOCACHE_BIT = 11;
  parameter int DIRTY_BIT = 10;
  parameter int VALID_BIT = 9;

  // bits kept by a write
  parameter logic [WORD_W-1:0] HI_KEEP = 32'hFFFF_FFC0;
  parameter logic [WORD_W-1:0] LO_KEEP = 32'hFFFF_FF00;

  parameter logic [VPN_W-1:0] UNMAPPED_BASE = 20'h80000;
  parameter logic [WORD_W-1:0] PROBE_NONE = 32'h8000_0000;

  typedef enum logic [1:0] {
    OP_WR_IDX  = 2'd0,
    OP_WR_RAND = 2'd1,
    OP_RD      = 2'd2,
    OP_PROBE   = 2'd3
  } tlbOp_t;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_MISS    = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_MODIFY  = 2'd3
  } tlbFault_t;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic             prEn;
    logic             lkEn;
    logic [IDX_W-1:0] slot;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdIndex,
  input  logic             lkValid,
  output tlbStrobe_t       strobe
);
  logic [IDX_W-1:0] randSlot;

  // free-running replacement pointer, counts down and wraps
  always_ff @(posedge clk) begin
    if (!rstN) randSlot <= IDX_W'(ENTRY_CNT - 1);
    else       randSlot <= randSlot - 1'b1;
  end

  always_comb begin
    strobe      = '0;
    strobe.lkEn = lkValid;
    strobe.slot = cmdIndex;
    if (cmdValid) begin
      case (tlbOp_t'(cmdOp))
        OP_WR_IDX:  strobe.wrEn = 1'b1;
        OP_WR_RAND: begin
          strobe.wrEn = 1'b1;
          strobe.slot = randSlot;
        end
        OP_RD:      strobe.rdEn = 1'b1;
        OP_PROBE:   strobe.prEn = 1'b1;
        default:    strobe.wrEn = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = ENTRY_CNT,
  localparam int IW = $clog2(ENTRIES)
)(
  input  logic [VPN_W-1:0] vpnTab [ENTRIES],
  input  logic [VPN_W-1:0] keyVpn,
  output logic             hit,
  output logic [IW-1:0]    idx,
  output logic             multi
);
  logic [ENTRIES-1:0] hitVec;

  // unmapped pages on either side never match
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitVec[g] = (vpnTab[g] == keyVpn) && !vpnTab[g][VPN_W-1] && !keyVpn[VPN_W-1];
  end

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) idx = IW'(i);
    end
  end

  assign hit   = |hitVec;
  assign multi = |(hitVec & (hitVec - 1'b1));
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = ENTRY_CNT
)(
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [WORD_W-1:0] cmdHi,
  input  logic [WORD_W-1:0] cmdLo,
  input  logic [WORD_W-1:0] lkAddr,
  input  logic              lkStore,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspHi,
  output logic [WORD_W-1:0] rspLo,
  output logic [WORD_W-1:0] rspProbe,
  output logic              rspMulti,
  output logic              lkDone,
  output logic [WORD_W-1:0] lkPaddr,
  output logic [1:0]        lkFault,
  output logic [VPN_W-1:0]  lkFaultVpn,
  output logic              lkNoCache,
  output logic              lkMulti
);
  logic [WORD_W-1:0] hiMem [ENTRIES];
  logic [WORD_W-1:0] loMem [ENTRIES];
  logic [VPN_W-1:0]  vpnTab [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tab
    assign vpnTab[g] = hiMem[g][WORD_W-1:PAGE_BITS];
  end

  // entry storage; reset fills each slot with its own unmapped page
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        hiMem[i] <= WORD_W'(({{PAGE_BITS{1'b0}}, UNMAPPED_BASE} + WORD_W'(i)) << PAGE_BITS);
        loMem[i] <= '0;
      end
    end else if (strobe.wrEn) begin
      hiMem[strobe.slot] <= cmdHi & HI_KEEP;
      loMem[strobe.slot] <= cmdLo & LO_KEEP;
    end
  end

  logic             prHit, prMulti;
  logic [IDX_W-1:0] prIdx;
  logic             lkHit, lkMul;
  logic [IDX_W-1:0] lkIdx;
  logic [VPN_W-1:0] lkVpn;

  assign lkVpn = lkAddr[WORD_W-1:PAGE_BITS];

  tlb_match #(.ENTRIES(ENTRIES)) i_probeMatch (
    .vpnTab(vpnTab), .keyVpn(cmdHi[WORD_W-1:PAGE_BITS]),
    .hit(prHit), .idx(prIdx), .multi(prMulti)
  );

  tlb_match #(.ENTRIES(ENTRIES)) i_lookMatch (
    .vpnTab(vpnTab), .keyVpn(lkVpn),
    .hit(lkHit), .idx(lkIdx), .multi(lkMul)
  );

  // lookup result decision
  logic [WORD_W-1:0] selLo;
  tlbFault_t         nextFault;
  logic [WORD_W-1:0] nextPaddr;

  always_comb begin
    selLo     = loMem[lkIdx];
    nextFault = FLT_NONE;
    nextPaddr = lkAddr;
    if (!lkVpn[VPN_W-1]) begin
      nextPaddr = {selLo[WORD_W-1:PAGE_BITS], lkAddr[PAGE_BITS-1:0]};
      if (!lkHit)                             nextFault = FLT_MISS;
      else if (!selLo[VALID_BIT])             nextFault = FLT_INVALID;
      else if (lkStore && !selLo[DIRTY_BIT])  nextFault = FLT_MODIFY;
      if (nextFault == FLT_MISS) nextPaddr = '0;
    end
  end

  // command responses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHi    <= '0;
      rspLo    <= '0;
      rspProbe <= '0;
      rspMulti <= 1'b0;
    end else begin
      rspValid <= strobe.rdEn | strobe.prEn;
      if (strobe.rdEn) begin
        rspHi    <= hiMem[strobe.slot];
        rspLo    <= loMem[strobe.slot];
        rspMulti <= 1'b0;
      end
      if (strobe.prEn) begin
        rspProbe <= prHit ? {{(WORD_W-IDX_W){1'b0}}, prIdx} : PROBE_NONE;
        rspMulti <= prMulti;
      end
    end
  end

  // lookup responses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkDone     <= 1'b0;
      lkPaddr    <= '0;
      lkFault    <= FLT_NONE;
      lkFaultVpn <= '0;
      lkNoCache  <= 1'b0;
      lkMulti    <= 1'b0;
    end else begin
      lkDone <= strobe.lkEn;
      if (strobe.lkEn) begin
        lkPaddr    <= nextPaddr;
        lkFault    <= nextFault;
        lkFaultVpn <= lkVpn;
        lkNoCache  <= lkHit && !lkVpn[VPN_W-1] && selLo[NOCACHE_BIT];
        lkMulti    <= lkMul && !lkVpn[VPN_W-1];
      end
    end
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [WORD_W-1:0] cmdHi,
  input  logic [WORD_W-1:0] cmdLo,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspHi,
  output logic [WORD_W-1:0] rspLo,
  output logic [WORD_W-1:0] rspProbe,
  output logic              rspMulti,
  input  logic              lkValid,
  input  logic [WORD_W-1:0] lkAddr,
  input  logic              lkStore,
  output logic              lkDone,
  output logic [WORD_W-1:0] lkPaddr,
  output logic [1:0]        lkFault,
  output logic [VPN_W-1:0]  lkFaultVpn,
  output logic              lkNoCache,
  output logic              lkMulti
);
  tlbStrobe_t strobe;

  tlb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIndex(cmdIndex), .lkValid(lkValid), .strobe(strobe)
  );

  tlb_datapath #(.ENTRIES(ENTRY_CNT)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdHi(cmdHi), .cmdLo(cmdLo),
    .lkAddr(lkAddr), .lkStore(lkStore),
    .rspValid(rspValid), .rspHi(rspHi), .rspLo(rspLo),
    .rspProbe(rspProbe), .rspMulti(rspMulti),
    .lkDone(lkDone), .lkPaddr(lkPaddr), .lkFault(lkFault),
    .lkFaultVpn(lkFaultVpn), .lkNoCache(lkNoCache), .lkMulti(lkMulti)
  );
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        rspValid,
  input logic [31:0] rspProbe,
  input logic        rspMulti,
  input logic        lkValid,
  input logic [31:0] lkAddr,
  input logic        lkStore,
  input logic        lkDone,
  input logic [31:0] lkPaddr,
  input logic [1:0]  lkFault,
  input logic [19:0] lkFaultVpn
);
  // R1
  rsp_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !rspValid);

  // R6
  lk_done_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> lkDone);

  // R6
  lk_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !lkDone);

  // R3
  probe_none_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspProbe[31]) |-> (rspProbe[30:0] == 31'd0));

  // R4
  multi_has_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMulti) |-> !rspProbe[31]);

  // R7
  miss_vpn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkAddr[31]) |=> (lkFaultVpn == $past(lkAddr[31:12])));

  // R10
  unmapped_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkAddr[31]) |=> (lkFault == 2'd0 && lkPaddr == $past(lkAddr)));

  // R9
  modify_on_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkStore) |=> (lkFault != 2'd3));
endmodule

bind tlb_assoc tlb_assoc_chk i_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .rspValid(rspValid),
  .rspProbe(rspProbe), .rspMulti(rspMulti), .lkValid(lkValid),
  .lkAddr(lkAddr), .lkStore(lkStore), .lkDone(lkDone), .lkPaddr(lkPaddr),
  .lkFault(lkFault), .lkFaultVpn(lkFaultVpn)
);

// File: tb/test_tlb_assoc.sv
module test_tlb_assoc;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [5:0]  cmdIndex = 6'd0;
  logic [31:0] cmdHi = '0;
  logic [31:0] cmdLo = '0;
  logic        rspValid;
  logic [31:0] rspHi, rspLo, rspProbe;
  logic        rspMulti;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        lkStore = 1'b0;
  logic        lkDone;
  logic [31:0] lkPaddr;
  logic [1:0]  lkFault;
  logic [19:0] lkFaultVpn;
  logic        lkNoCache, lkMulti;

  tlb_assoc i_tlb_assoc (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          isProbe;
    logic [31:0] e0;
    logic [31:0] e1;
    string       tag;
  } cmdExp_t;

  typedef struct {
    logic [31:0] paddr;
    logic [1:0]  fault;
    logic [19:0] vpn;
    logic        noCache;
    logic        multi;
    string       tag;
  } lkExp_t;

  cmdExp_t cmdQ[$];
  lkExp_t  lkQ[$];
  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rstN) cyc++;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // command response monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (cmdQ.size() == 0) check(1'b0, "unexpected rspValid", 32'd1, 32'd0);
      else begin
        cmdExp_t e;
        e = cmdQ.pop_front();
        if (e.isProbe) begin
          check(rspProbe === e.e0, e.tag, rspProbe, e.e0);
          check(rspMulti === e.e1[0], {e.tag, " multi"}, {31'd0, rspMulti}, e.e1);
        end else begin
          check(rspHi === e.e0, {e.tag, " hi"}, rspHi, e.e0);
          check(rspLo === e.e1, {e.tag, " lo"}, rspLo, e.e1);
        end
      end
    end
  end

  // lookup monitor
  always @(negedge clk) begin
    if (rstN && lkDone) begin
      if (lkQ.size() == 0) check(1'b0, "unexpected lkDone", 32'd1, 32'd0);
      else begin
        lkExp_t e;
        e = lkQ.pop_front();
        check(lkFault === e.fault, {e.tag, " fault"}, {30'd0, lkFault}, {30'd0, e.fault});
        if (e.fault == 2'd0) begin
          check(lkPaddr === e.paddr, {e.tag, " paddr"}, lkPaddr, e.paddr);
          check(lkNoCache === e.noCache, {e.tag, " nocache"}, {31'd0, lkNoCache}, {31'd0, e.noCache});
        end else begin
          check(lkFaultVpn === e.vpn, {e.tag, " vpn"}, {12'd0, lkFaultVpn}, {12'd0, e.vpn});
        end
        check(lkMulti === e.multi, {e.tag, " multi"}, {31'd0, lkMulti}, {31'd0, e.multi});
      end
    end
  end

  task automatic doWrite(input logic [5:0] idx, input logic [31:0] hi, input logic [31:0] lo);
    cmdValid = 1'b1; cmdOp = 2'd0; cmdIndex = idx; cmdHi = hi; cmdLo = lo;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doRandWrite(input logic [31:0] hi, input logic [31:0] lo, output logic [5:0] slot);
    slot = 6'(63 - (cyc % 64));
    cmdValid = 1'b1; cmdOp = 2'd1; cmdHi = hi; cmdLo = lo;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doRead(input logic [5:0] idx, input logic [31:0] expHi, input logic [31:0] expLo, input string tag);
    cmdExp_t e;
    e.isProbe = 1'b0; e.e0 = expHi; e.e1 = expLo; e.tag = tag;
    cmdQ.push_back(e);
    cmdValid = 1'b1; cmdOp = 2'd2; cmdIndex = idx;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doProbe(input logic [31:0] hi, input logic [31:0] expRes, input bit expMulti, input string tag);
    cmdExp_t e;
    e.isProbe = 1'b1; e.e0 = expRes; e.e1 = {31'd0, expMulti}; e.tag = tag;
    cmdQ.push_back(e);
    cmdValid = 1'b1; cmdOp = 2'd3; cmdHi = hi; cmdLo = '0;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doLookup(input logic [31:0] addr, input bit store, input logic [31:0] expPa,
                          input logic [1:0] expFault, input bit expNc, input bit expMulti, input string tag);
    lkExp_t e;
    e.paddr = expPa; e.fault = expFault; e.vpn = addr[31:12];
    e.noCache = expNc; e.multi = expMulti; e.tag = tag;
    lkQ.push_back(e);
    lkValid = 1'b1; lkAddr = addr; lkStore = store;
    @(negedge clk);
    lkValid = 1'b0; lkStore = 1'b0;
  endtask

  initial begin
    logic [5:0] s1, s2, s3;
    repeat (3) @(negedge clk);
    check(rspValid === 1'b0 && lkDone === 1'b0, "R1 outputs idle in reset",
          {30'd0, rspValid, lkDone}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset contents
    doRead(6'd0,  32'h8000_0000, 32'h0, "R1 slot0");
    doRead(6'd63, 32'h8003_F000, 32'h0, "R1 slot63");
    // R7 nothing mapped yet
    doLookup(32'h0000_1234, 1'b0, 32'h0, 2'd1, 1'b0, 1'b0, "R7 miss");

    // R2 masking of unused bits
    doWrite(6'd3, 32'h1234_5FFF, 32'h6789_AFFF);
    doRead(6'd3, 32'h1234_5FC0, 32'h6789_AF00, "R2 readback");
    // R6 translation with no-cache reported
    doLookup(32'h1234_5ABC, 1'b0, 32'h6789_AABC, 2'd0, 1'b1, 1'b0, "R6 load hit");
    doLookup(32'h1234_5ABC, 1'b1, 32'h6789_AABC, 2'd0, 1'b1, 1'b0, "R6 store hit dirty");

    // R9 write permission
    doWrite(6'd4, 32'h0040_0000, 32'h0077_7200);
    doLookup(32'h0040_0010, 1'b1, 32'h0, 2'd3, 1'b0, 1'b0, "R9 store no dirty");
    doLookup(32'h0040_0010, 1'b0, 32'h0077_7010, 2'd0, 1'b0, 1'b0, "R9 load ok");
    doRead(6'd4, 32'h0040_0000, 32'h0077_7200, "R9 dirty unchanged");

    // R8 invalid entry, R3 probe ignores valid
    doWrite(6'd5, 32'h0050_0000, 32'h0088_8000);
    doLookup(32'h0050_0004, 1'b0, 32'h0, 2'd2, 1'b0, 1'b0, "R8 invalid");
    doProbe(32'h0050_0000, 32'd5, 1'b0, "R3 probe invalid entry");
    doProbe(32'h0099_9000, 32'h8000_0000, 1'b0, "R3 probe none");
    doProbe(32'h0040_0FC0, 32'd4, 1'b0, "R3 probe ignores tag bits");

    // R4 duplicate pages
    doWrite(6'd20, 32'h0050_0000, 32'h00AA_A200);
    doProbe(32'h0050_0000, 32'd5, 1'b1, "R4 probe multi");
    doLookup(32'h0050_0000, 1'b0, 32'h0, 2'd2, 1'b0, 1'b1, "R4 lookup multi");

    // R10 unmapped space
    doLookup(32'h8000_1234, 1'b1, 32'h8000_1234, 2'd0, 1'b0, 1'b0, "R10 bypass");
    doWrite(6'd7, 32'h9000_0000, 32'h0012_3600);
    doLookup(32'h9000_0008, 1'b0, 32'h9000_0008, 2'd0, 1'b0, 1'b0, "R10 bypass ignores slot");
    doProbe(32'h8000_0000, 32'h8000_0000, 1'b0, "R10 unmapped slot never matches");
    doProbe(32'h9000_0000, 32'h8000_0000, 1'b0, "R10 written unmapped never matches");

    // R11 back-to-back write then lookup
    doWrite(6'd8, 32'h00A0_0000, 32'h00B0_0600);
    doLookup(32'h00A0_0044, 1'b1, 32'h00B0_0044, 2'd0, 1'b0, 1'b0, "R11 next-cycle hit");

    // R5 random slot
    doRandWrite(32'h00C0_0000, 32'h00D0_0200, s1);
    doRandWrite(32'h00C1_0000, 32'h00D1_0200, s2);
    check(s2 == 6'(s1 - 6'd1), "R5 consecutive slots", {26'd0, s2}, {26'd0, 6'(s1 - 6'd1)});
    doProbe(32'h00C0_0000, {26'd0, s1}, 1'b0, "R5 probe first random");
    doRead(s2, 32'h00C1_0000, 32'h00D1_0200, "R5 read second random");
    repeat (5) @(negedge clk);
    doRandWrite(32'h00C2_0000, 32'h00D2_0200, s3);
    doProbe(32'h00C2_0000, {26'd0, s3}, 1'b0, "R5 probe after idle gap");

    repeat (4) @(negedge clk);
    check(cmdQ.size() == 0, "R2 pending cmd results", cmdQ.size(), 32'd0);
    check(lkQ.size() == 0, "R6 pending lookup results", lkQ.size(), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule